// File: doc/BRIEF.md
# Two-Level Lookahead 64-Bit Adder

This block adds two 64-bit unsigned operands and an input carry. It produces a 64-bit sum and a carry out. It is purely combinational and is written as explicit two-level AND-OR lookahead logic, so the gate depth of every path can be read straight off the source.

The carry tree has three levels:

- **Bit level.** Each bit forms a generate term (a AND b) and a propagate term (a XOR b).
- **Group level.** Each 4-bit group combines its bit terms into a group generate and a group propagate.
- **Section level.** Four groups make a 16-bit section, and a lookahead stage inside the section combines the group terms into a section generate and a section propagate.

At the top, one more lookahead stage of the same form takes the four section terms and the input carry. It forms the carries into bits 16, 32 and 48 and the final carry out, all in parallel, so no carry ripples between sections.

Counting one gate delay per AND, OR or XOR level:

- The carry out settles after 7 gate delays.
- The most significant sum bit settles after 12 gate delays.

Top module: `cla64_adder`

## Requirements
- R1: `sum_o` equals the low 64 bits of `a_i + b_i + cin_i` for every operand pair and both carry-in values.
- R2: `cout_o` equals bit 64 of the 65-bit result of `a_i + b_i + cin_i`.
- R3: The carry entering bit 16, bit 32 and bit 48 equals the carry out of an addition of the operand bits below that position together with `cin_i`. At the ports this is seen as the sum bit at that position when the operand bits at that position are both 0.
- R4: With `a_i` all ones, `b_i` equal to 1 and `cin_i` equal to 0, `sum_o` is 0 and `cout_o` is 1.
- R5: With `a_i` all ones, `b_i` equal to 0 and `cin_i` equal to 1, `sum_o` is 0 and `cout_o` is 1. With `cin_i` equal to 0 instead, `sum_o` is all ones and `cout_o` is 0.
- R6: The block holds no state. Outputs depend only on the present inputs, so all-zero inputs give an all-zero sum and a zero carry out, whatever values were applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum modulo 2^64 |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
Both results are combinational and are due in the same clock cycle as the stimulus, with zero registers on the path. The bench therefore changes the operands on a rising edge and compares `sum_o` and `cout_o` at the falling edge of that same cycle, half a period later, after the logic has settled. The section carries are checked inside the design against a behavioural addition of the lower operand bits. At the ports, sum bits 16, 32 and 48 are checked with operands that force a carry across each section boundary.

// File: rtl/cla64_pkg.sv
package cla64_pkg;
  // Lookahead radix: lanes combined by every lookahead stage.
  localparam int LANES     = 4;
  // Bits per section and overall width follow from the radix.
  localparam int SEC_W     = LANES * LANES;
  localparam int ADD_W     = SEC_W * LANES;
endpackage

// File: rtl/cla_carry_unit.sv
// Two-level carry lookahead: carries 1..NC from lane generate/propagate and carry-in.
module cla_carry_unit #(
  parameter int LANES = 4,
  parameter int NC    = LANES - 1
) (
  input  logic [LANES-1:0] g_i,
  input  logic [LANES-1:0] p_i,
  input  logic             c_i,
  output logic [NC:1]      c_o
);
  logic acc;
  logic term;

  always_comb begin
    c_o  = '0;
    acc  = 1'b0;
    term = 1'b0;
    for (int k = 1; k <= NC; k++) begin
      // product term carrying the input carry through all lower lanes
      term = c_i;
      for (int m = 0; m < k; m++) term = term & p_i[m];
      acc = term;
      // product terms for each lane generating and the rest propagating
      for (int j = 0; j < k; j++) begin
        term = g_i[j];
        for (int m = j + 1; m < k; m++) term = term & p_i[m];
        acc = acc | term;
      end
      c_o[k] = acc;
    end
  end
endmodule

// File: rtl/cla_group_gp.sv
// Two-level group generate / propagate over LANES lanes.
module cla_group_gp #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] g_i,
  input  logic [LANES-1:0] p_i,
  output logic             grp_g_o,
  output logic             grp_p_o
);
  logic term;

  always_comb begin
    grp_p_o = 1'b1;
    for (int m = 0; m < LANES; m++) grp_p_o = grp_p_o & p_i[m];
    grp_g_o = 1'b0;
    term    = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      term = g_i[j];
      for (int m = j + 1; m < LANES; m++) term = term & p_i[m];
      grp_g_o = grp_g_o | term;
    end
  end
endmodule

// File: rtl/cla_section.sv
// One section: LANES groups of LANES bits, with an inner lookahead stage.
module cla_section #(
  parameter int LANES = 4,
  localparam int SW   = LANES * LANES
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          c_i,
  output logic [SW-1:0] sum_o,
  output logic          sec_g_o,
  output logic          sec_p_o
);
  logic [SW-1:0]    bit_g;
  logic [SW-1:0]    bit_p;
  logic [SW-1:0]    bit_c;
  logic [LANES-1:0] grp_g;
  logic [LANES-1:0] grp_p;
  logic [LANES-1:0] grp_c;

  // Bit level: one gate each
  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  // Group carries from the section's inner lookahead stage
  assign grp_c[0] = c_i;

  cla_carry_unit #(.LANES(LANES), .NC(LANES - 1)) u_grp_carry (
    .g_i (grp_g),
    .p_i (grp_p),
    .c_i (c_i),
    .c_o (grp_c[LANES-1:1])
  );

  cla_group_gp #(.LANES(LANES)) u_sec_gp (
    .g_i     (grp_g),
    .p_i     (grp_p),
    .grp_g_o (sec_g_o),
    .grp_p_o (sec_p_o)
  );

  for (genvar gi = 0; gi < LANES; gi++) begin : g_grp
    localparam int LO = gi * LANES;

    cla_group_gp #(.LANES(LANES)) u_gp (
      .g_i     (bit_g[LO +: LANES]),
      .p_i     (bit_p[LO +: LANES]),
      .grp_g_o (grp_g[gi]),
      .grp_p_o (grp_p[gi])
    );

    assign bit_c[LO] = grp_c[gi];

    cla_carry_unit #(.LANES(LANES), .NC(LANES - 1)) u_bit_carry (
      .g_i (bit_g[LO +: LANES]),
      .p_i (bit_p[LO +: LANES]),
      .c_i (grp_c[gi]),
      .c_o (bit_c[LO+LANES-1 : LO+1])
    );
  end

  assign sum_o = bit_p ^ bit_c;
endmodule

// File: rtl/cla64_adder.sv
// Top: LANES sections joined by a section-level lookahead stage.
module cla64_adder
  import cla64_pkg::*;
(
  input  logic [ADD_W-1:0] a_i,
  input  logic [ADD_W-1:0] b_i,
  input  logic             cin_i,
  output logic [ADD_W-1:0] sum_o,
  output logic             cout_o
);
  logic [LANES-1:0] sec_g;
  logic [LANES-1:0] sec_p;
  logic [LANES:0]   sec_carry;

  assign sec_carry[0] = cin_i;

  // Carries into each section and out of the top, all from cin_i and section G/P
  cla_carry_unit #(.LANES(LANES), .NC(LANES)) u_top_carry (
    .g_i (sec_g),
    .p_i (sec_p),
    .c_i (cin_i),
    .c_o (sec_carry[LANES:1])
  );

  for (genvar si = 0; si < LANES; si++) begin : g_sec
    cla_section #(.LANES(LANES)) u_sec (
      .a_i     (a_i[si*SEC_W +: SEC_W]),
      .b_i     (b_i[si*SEC_W +: SEC_W]),
      .c_i     (sec_carry[si]),
      .sum_o   (sum_o[si*SEC_W +: SEC_W]),
      .sec_g_o (sec_g[si]),
      .sec_p_o (sec_p[si])
    );
  end

  assign cout_o = sec_carry[LANES];
endmodule

// File: rtl/cla64_adder_chk.sv
// Checker bound to the top: compares gate-level results with behavioural sums.
module cla64_adder_chk
  import cla64_pkg::*;
(
  input logic [ADD_W-1:0] a_i,
  input logic [ADD_W-1:0] b_i,
  input logic             cin_i,
  input logic [ADD_W-1:0] sum_o,
  input logic             cout_o,
  input logic [LANES:0]   sec_carry
);
  logic [ADD_W:0]  ref_full;
  logic [SEC_W:0]  ref_part;
  logic [ADD_W-1:0] low_mask;

  always_comb begin
    ref_full = {1'b0, a_i} + {1'b0, b_i} + {{ADD_W{1'b0}}, cin_i};

    assert_sum_matches_R1: assert (sum_o == ref_full[ADD_W-1:0])
      else $error("R1 sum mismatch");

    assert_cout_matches_R2: assert (cout_o == ref_full[ADD_W])
      else $error("R2 carry-out mismatch");

    assert_all_ones_wrap_R4: assert (!(a_i == '1 && b_i == 'd1 && !cin_i) ||
                                     (sum_o == '0 && cout_o))
      else $error("R4 all-ones plus one wrong");

    assert_zero_inputs_R6: assert (!(a_i == '0 && b_i == '0 && !cin_i) ||
                                   (sum_o == '0 && !cout_o))
      else $error("R6 zero inputs gave nonzero result");

    ref_part = '0;
    low_mask = '0;
    for (int s = 1; s < LANES; s++) begin
      low_mask = ({ADD_W{1'b1}} >> (ADD_W - s*SEC_W));
      ref_part = '0;
      begin
        logic [ADD_W:0] t;
        t = {1'b0, a_i & low_mask} + {1'b0, b_i & low_mask} + {{ADD_W{1'b0}}, cin_i};
        ref_part[0] = t[s*SEC_W];
      end
      assert_section_carry_R3: assert (sec_carry[s] == ref_part[0])
        else $error("R3 section carry %0d mismatch", s);
    end
  end
endmodule

bind cla64_adder cla64_adder_chk u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .sec_carry (sec_carry)
);

// File: tb/cla64_adder_tb.sv
module cla64_adder_tb;
  localparam int W = 64;
  localparam int N_VEC = 10;
  localparam int N_RAND = 300;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
    '{64'h0000_0000_0000_0005, 64'h0000_0000_0000_0006, 1'b0},
    '{64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 1'b0},
    '{64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1},
    '{64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1},
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0},
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}
  };

  logic         clk;
  logic [W-1:0] a_i;
  logic [W-1:0] b_i;
  logic         cin_i;
  logic [W-1:0] sum_o;
  logic         cout_o;

  int n_chk;
  int n_fail;
  bit done;

  cla64_adder u_dut (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    @(posedge clk);
    a_i   = a;
    b_i   = b;
    cin_i = ci;
    @(negedge clk);
  endtask

  task automatic check_full(input string req);
    logic [W:0] ref_v;
    ref_v = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    n_chk++;
    if (sum_o !== ref_v[W-1:0]) begin
      n_fail++;
      $display("FAIL %s R1 sum: actual %h expected %h", req, sum_o, ref_v[W-1:0]);
    end
    n_chk++;
    if (cout_o !== ref_v[W]) begin
      n_fail++;
      $display("FAIL %s R2 cout: actual %b expected %b", req, cout_o, ref_v[W]);
    end
  endtask

  task automatic check_val(input string req, input logic [W-1:0] es, input logic ec);
    n_chk++;
    if (sum_o !== es || cout_o !== ec) begin
      n_fail++;
      $display("FAIL %s: actual %h/%b expected %h/%b", req, sum_o, cout_o, es, ec);
    end
  endtask

  task automatic check_bit(input string req, input int pos, input logic ev);
    n_chk++;
    if (sum_o[pos] !== ev) begin
      n_fail++;
      $display("FAIL %s bit %0d: actual %b expected %b", req, pos, sum_o[pos], ev);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    a_i    = '0;
    b_i    = '0;
    cin_i  = 1'b0;

    // R6: zero inputs give zero outputs from the start
    @(negedge clk);
    check_val("R6 initial zero", '0, 1'b0);

    // R1/R2: vector table
    for (int i = 0; i < N_VEC; i++) begin
      drive(VECS[i].a, VECS[i].b, VECS[i].ci);
      check_full("R1/R2 table");
    end

    // R1/R2: random operands, both carry-in values
    for (int i = 0; i < N_RAND; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      check_full("R1/R2 random");
    end

    // R3: force a carry across each section boundary
    for (int s = 1; s < 4; s++) begin
      logic [W-1:0] lo;
      lo = {W{1'b1}} >> (W - 16*s);
      drive(lo, '0, 1'b1);
      check_bit("R3 boundary carry", 16*s, 1'b1);
      drive(lo, '0, 1'b0);
      check_bit("R3 boundary no carry", 16*s, 1'b0);
    end

    // R4: all ones plus one
    drive('1, 64'd1, 1'b0);
    check_val("R4 all-ones plus one", '0, 1'b1);

    // R5: all ones with carry-in, and without
    drive('1, '0, 1'b1);
    check_val("R5 all-ones plus cin", '0, 1'b1);
    drive('1, '0, 1'b0);
    check_val("R5 all-ones no cin", '1, 1'b0);

    // R6: back to zero after heavy activity, no memory of past inputs
    drive('1, '1, 1'b1);
    drive('0, '0, 1'b0);
    check_val("R6 zero after activity", '0, 1'b0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule